// File: doc/BRIEF.md
# DRAM Clock-Change Power-Down Sequencer

This block sits on the controller side of a DDR2-style memory interface. It lets the memory clock frequency be changed safely while the device is held in precharge power-down. It accepts a single-cycle request only when it is idle and all banks are reported precharged. It then drives the clock-enable and termination-enable pins low and keeps them low for a minimum entry time. After that it opens a frequency-change window toward an external clock generator and waits for that generator to report that the new clock is stable.

Once the clock is stable, the sequencer waits a short settle time and raises clock-enable to leave power-down. It honours the exit latency and then places a mode-register load with the DLL-reset bit set on the command bus. Termination stays off for the whole DLL relock interval. When the request carried an update flag, the sequencer also writes the new CAS latency and write-recovery values to the main mode register, and the new additive latency to the extended mode register. A one-cycle ready pulse closes the sequence. While the sequence runs, a busy flag tells other command sources to stay off the bus.

Top module: `dram_fclk_seq`

## Requirements
- R1: After reset the block is idle: busy_o, ready_o, err_o and freq_change_ok_o are low, cke_o is high and cmd_o is NOP (2'b00).
- R2: A request (req_i high while idle with banks_idle_i high) makes busy_o high and cke_o low in the next cycle; cke_o stays low until the exit described in R5.
- R3: freq_change_ok_o rises exactly PD_ENTRY_CYC cycles (default 2) after cke_o falls, and stays high until the cycle after clk_stable_i is sampled high while it is high.
- R4: clk_stable_i is ignored while freq_change_ok_o is low; a pulse during the entry wait does not shorten or skip the window.
- R5: After clk_stable_i is accepted, cke_o stays low for SETTLE_CYC more cycles (default 1) and then rises.
- R6: After cke_o rises, TXP_CYC NOP cycles (default 2) follow, then one load-mode command (cmd_o 2'b01) to bank address 0 with addr_o bit 8 set, the current CAS latency in bits 6:4, the current write recovery in bits 11:9, and the burst code BL_CODE in bits 2:0.
- R7: With upd_lat_i high at the request, TMRD_CYC NOP cycles after the DLL-reset load a second load to bank 0 carries new_cl_i in bits 6:4 and new_wr_i in bits 11:9 with bit 8 clear. TMRD_CYC NOP cycles later a third load to bank 1 carries new_al_i in bits 5:3. The new latency values are then used by later DLL-reset loads.
- R8: With upd_lat_i low at the request, exactly one load-mode command is issued in the sequence.
- R9: odt_o is low from the cycle after acceptance until ready_o. ready_o pulses for one cycle exactly RELOCK_CYC cycles (default 200) after the DLL-reset load, and busy_o is low in the following cycle.
- R10: While cke_o is low, and in every busy cycle other than the loads of R6 and R7, cmd_o is NOP.
- R11: err_o is high in any cycle where req_i is high while busy_o is high or banks_idle_i is low, and such a request starts no sequence.
- R12: While idle, odt_o follows odt_i and cke_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request to run a clock-change sequence |
| banks_idle_i | input | 1 | All banks are precharged |
| upd_lat_i | input | 1 | Reprogram latency fields after relock |
| new_cl_i | input | 3 | New CAS latency code |
| new_wr_i | input | 3 | New write recovery code |
| new_al_i | input | 3 | New additive latency code |
| clk_stable_i | input | 1 | Clock generator reports the new clock stable |
| odt_i | input | 1 | Termination request from the normal command path |
| cke_o | output | 1 | Clock enable to the device |
| odt_o | output | 1 | Termination enable to the device |
| freq_change_ok_o | output | 1 | Frequency-change window granted |
| cmd_o | output | 2 | Command: 2'b00 NOP, 2'b01 load mode |
| ba_o | output | 2 | Bank address of the load (0 main, 1 extended) |
| addr_o | output | ADDR_W | Mode word of the load, zero on NOP |
| busy_o | output | 1 | Sequence in progress, other sources blocked |
| ready_o | output | 1 | One-cycle pulse when the sequence is complete |
| err_o | output | 1 | Rejected request |

## Verification
The bench pulses clk_stable_i during the entry wait. A design that sampled the acknowledge too early would skip the window or shorten the minimum entry interval. It also holds the acknowledge high from acceptance, and a correct design then grants the window for exactly one cycle, where an off-by-one would grant it twice or not at all. Requests arrive while busy and while banks are open; an implementation that restarted or queued them would disturb the clock-enable timeline. Runs with and without the update flag, followed by a run that reuses the new values, expose a design that drops the extra loads, misplaces the WR field, forgets to commit the new latencies, or ends relock one cycle early or late.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PDE,
      S_WIN,
      S_SET,
      S_XP,
      S_LMD,
      S_MRD,
      S_LMM,
      S_LME,
      S_LCK
   } seq_st_e;

   localparam logic [1:0] CMD_NOP = 2'b00;
   localparam logic [1:0] CMD_LMR = 2'b01;

   localparam logic [1:0] BA_MR  = 2'd0;
   localparam logic [1:0] BA_EMR = 2'd1;

   // mode word field positions the device decodes
   localparam int BL_LSB  = 0;
   localparam int CL_LSB  = 4;
   localparam int DLL_BIT = 8;
   localparam int WR_LSB  = 9;
   localparam int AL_LSB  = 3;

endpackage

// File: rtl/dfc_timer.sv
module dfc_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (ld)
         cnt <= ld_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/dfc_fsm.sv
module dfc_fsm
   import dfc_pkg::*;
#(
   parameter int          PD_ENTRY_CYC = 2,
   parameter int          SETTLE_CYC   = 1,
   parameter int          TXP_CYC      = 2,
   parameter int          TMRD_CYC     = 2,
   parameter int          TW           = 2,
   parameter logic [2:0]  INIT_CL      = 3'd4,
   parameter logic [2:0]  INIT_WR      = 3'd2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          banks_idle_i,
   input  logic          upd_lat_i,
   input  logic [2:0]    new_cl_i,
   input  logic [2:0]    new_wr_i,
   input  logic [2:0]    new_al_i,
   input  logic          clk_stable_i,
   input  logic          tmr_zero,
   input  logic          rl_zero,
   output seq_st_e       st,
   output logic          tmr_ld,
   output logic [TW-1:0] tmr_val,
   output logic          rl_ld,
   output logic [2:0]    cur_cl,
   output logic [2:0]    cur_wr,
   output logic [2:0]    pend_cl,
   output logic [2:0]    pend_wr,
   output logic [2:0]    pend_al
);

   seq_st_e    nxt;
   logic       upd_q;
   logic [1:0] idx;
   logic       accept;

   assign accept = (st == S_IDLE) && req_i && banks_idle_i;

   always_comb begin
      nxt     = st;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      rl_ld   = 1'b0;
      case (st)
         S_IDLE: if (accept) begin
            nxt     = S_PDE;
            tmr_ld  = 1'b1;
            tmr_val = TW'(PD_ENTRY_CYC - 1);
         end
         S_PDE: if (tmr_zero) nxt = S_WIN;
         S_WIN: if (clk_stable_i) begin
            nxt     = S_SET;
            tmr_ld  = 1'b1;
            tmr_val = TW'(SETTLE_CYC - 1);
         end
         S_SET: if (tmr_zero) begin
            nxt     = S_XP;
            tmr_ld  = 1'b1;
            tmr_val = TW'(TXP_CYC - 1);
         end
         S_XP: if (tmr_zero) nxt = S_LMD;
         S_LMD: begin
            nxt     = S_MRD;
            tmr_ld  = 1'b1;
            tmr_val = TW'(TMRD_CYC - 1);
            rl_ld   = 1'b1;
         end
         S_MRD: if (tmr_zero) begin
            if (upd_q && idx == 2'd0)
               nxt = S_LMM;
            else if (upd_q && idx == 2'd1)
               nxt = S_LME;
            else
               nxt = S_LCK;
         end
         S_LMM, S_LME: begin
            nxt     = S_MRD;
            tmr_ld  = 1'b1;
            tmr_val = TW'(TMRD_CYC - 1);
         end
         S_LCK: if (rl_zero) nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         upd_q   <= 1'b0;
         idx     <= 2'd0;
         cur_cl  <= INIT_CL;
         cur_wr  <= INIT_WR;
         pend_cl <= '0;
         pend_wr <= '0;
         pend_al <= '0;
      end else begin
         st <= nxt;
         if (accept) begin
            upd_q   <= upd_lat_i;
            pend_cl <= new_cl_i;
            pend_wr <= new_wr_i;
            pend_al <= new_al_i;
         end
         case (st)
            S_LMD: idx <= 2'd0;
            S_LMM: begin
               idx    <= 2'd1;
               cur_cl <= pend_cl;
               cur_wr <= pend_wr;
            end
            S_LME: idx <= 2'd2;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dfc_cmd_enc.sv
module dfc_cmd_enc
   import dfc_pkg::*;
#(
   parameter int         ADDR_W  = 14,
   parameter logic [2:0] BL_CODE = 3'b010
) (
   input  seq_st_e           st,
   input  logic [2:0]        cur_cl,
   input  logic [2:0]        cur_wr,
   input  logic [2:0]        pend_cl,
   input  logic [2:0]        pend_wr,
   input  logic [2:0]        pend_al,
   output logic [1:0]        cmd,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr
);

   function automatic logic [ADDR_W-1:0] mr_word(input logic [2:0] cl,
                                                 input logic [2:0] wr,
                                                 input logic       dll);
      logic [ADDR_W-1:0] w;
      w                = '0;
      w[BL_LSB +: 3]   = BL_CODE;
      w[CL_LSB +: 3]   = cl;
      w[DLL_BIT]       = dll;
      w[WR_LSB +: 3]   = wr;
      return w;
   endfunction

   always_comb begin
      cmd  = CMD_NOP;
      ba   = BA_MR;
      addr = '0;
      case (st)
         S_LMD: begin
            cmd  = CMD_LMR;
            addr = mr_word(cur_cl, cur_wr, 1'b1);
         end
         S_LMM: begin
            cmd  = CMD_LMR;
            addr = mr_word(pend_cl, pend_wr, 1'b0);
         end
         S_LME: begin
            cmd              = CMD_LMR;
            ba               = BA_EMR;
            addr[AL_LSB +: 3] = pend_al;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dram_fclk_seq.sv
module dram_fclk_seq
   import dfc_pkg::*;
#(
   parameter int         PD_ENTRY_CYC = 2,
   parameter int         SETTLE_CYC   = 1,
   parameter int         TXP_CYC      = 2,
   parameter int         TMRD_CYC     = 2,
   parameter int         RELOCK_CYC   = 200,
   parameter int         ADDR_W       = 14,
   parameter logic [2:0] BL_CODE      = 3'b010,
   parameter logic [2:0] INIT_CL      = 3'd4,
   parameter logic [2:0] INIT_WR      = 3'd2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              banks_idle_i,
   input  logic              upd_lat_i,
   input  logic [2:0]        new_cl_i,
   input  logic [2:0]        new_wr_i,
   input  logic [2:0]        new_al_i,
   input  logic              clk_stable_i,
   input  logic              odt_i,
   output logic              cke_o,
   output logic              odt_o,
   output logic              freq_change_ok_o,
   output logic [1:0]        cmd_o,
   output logic [1:0]        ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              busy_o,
   output logic              ready_o,
   output logic              err_o
);

   localparam int T_A   = (PD_ENTRY_CYC > SETTLE_CYC) ? PD_ENTRY_CYC : SETTLE_CYC;
   localparam int T_B   = (TXP_CYC > TMRD_CYC) ? TXP_CYC : TMRD_CYC;
   localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
   localparam int TW    = (T_MAX < 2) ? 1 : $clog2(T_MAX);
   localparam int RW    = $clog2(RELOCK_CYC);
   localparam int LOAD_SPAN = 3 * TMRD_CYC + 3;

   generate
      if (PD_ENTRY_CYC < 2) begin : g_chk_pd
         $error("PD_ENTRY_CYC must be at least 2");
      end
      if (SETTLE_CYC < 1 || TXP_CYC < 1 || TMRD_CYC < 1) begin : g_chk_min
         $error("SETTLE_CYC, TXP_CYC and TMRD_CYC must be at least 1");
      end
      if (RELOCK_CYC <= LOAD_SPAN) begin : g_chk_rl
         $error("RELOCK_CYC must exceed the span of the extra loads");
      end
      if (ADDR_W < 12) begin : g_chk_aw
         $error("ADDR_W must hold the write recovery field");
      end
   endgenerate

   seq_st_e       st;
   logic          tmr_ld, tmr_zero, rl_ld, rl_zero;
   logic [TW-1:0] tmr_val;
   logic [2:0]    cur_cl, cur_wr, pend_cl, pend_wr, pend_al;

   dfc_fsm #(
      .PD_ENTRY_CYC(PD_ENTRY_CYC),
      .SETTLE_CYC  (SETTLE_CYC),
      .TXP_CYC     (TXP_CYC),
      .TMRD_CYC    (TMRD_CYC),
      .TW          (TW),
      .INIT_CL     (INIT_CL),
      .INIT_WR     (INIT_WR)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .banks_idle_i(banks_idle_i),
      .upd_lat_i   (upd_lat_i),
      .new_cl_i    (new_cl_i),
      .new_wr_i    (new_wr_i),
      .new_al_i    (new_al_i),
      .clk_stable_i(clk_stable_i),
      .tmr_zero    (tmr_zero),
      .rl_zero     (rl_zero),
      .st          (st),
      .tmr_ld      (tmr_ld),
      .tmr_val     (tmr_val),
      .rl_ld       (rl_ld),
      .cur_cl      (cur_cl),
      .cur_wr      (cur_wr),
      .pend_cl     (pend_cl),
      .pend_wr     (pend_wr),
      .pend_al     (pend_al)
   );

   // interval timer shared by entry, settle, exit and load spacing
   dfc_timer #(.W(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (tmr_ld),
      .ld_val(tmr_val),
      .zero  (tmr_zero)
   );

   // relock timer runs alongside the extra loads
   dfc_timer #(.W(RW)) u_relock (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (rl_ld),
      .ld_val(RW'(RELOCK_CYC - 1)),
      .zero  (rl_zero)
   );

   dfc_cmd_enc #(
      .ADDR_W (ADDR_W),
      .BL_CODE(BL_CODE)
   ) u_enc (
      .st     (st),
      .cur_cl (cur_cl),
      .cur_wr (cur_wr),
      .pend_cl(pend_cl),
      .pend_wr(pend_wr),
      .pend_al(pend_al),
      .cmd    (cmd_o),
      .ba     (ba_o),
      .addr   (addr_o)
   );

   assign busy_o           = (st != S_IDLE);
   assign cke_o            = !(st == S_PDE || st == S_WIN || st == S_SET);
   assign freq_change_ok_o = (st == S_WIN);
   assign odt_o            = (st == S_IDLE) ? odt_i : 1'b0;
   assign ready_o          = (st == S_LCK) && rl_zero;
   assign err_o            = req_i && (busy_o || !banks_idle_i);

endmodule

// File: rtl/dfc_sva.sv
module dfc_sva
   import dfc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cke_o,
   input logic       odt_o,
   input logic       freq_change_ok_o,
   input logic [1:0] cmd_o,
   input logic       busy_o,
   input logic       ready_o,
   input logic       err_o
);

   p_entry_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(freq_change_ok_o) |-> (!$past(cke_o) && !$past(cke_o, 2)));

   p_window_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      freq_change_ok_o |-> (!cke_o && !odt_o && cmd_o == CMD_NOP));

   p_pd_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_o |-> (cmd_o == CMD_NOP && busy_o));

   p_load_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_LMR) |-> (cke_o && busy_o && !odt_o));

   p_odt_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !odt_o);

   p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> (!ready_o && !busy_o));

   p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !busy_o) |=> !busy_o);

   p_exit_after_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cke_o) && busy_o) |-> !$past(freq_change_ok_o));

endmodule

bind dram_fclk_seq dfc_sva u_sva (
   .clk             (clk),
   .rst_n           (rst_n),
   .cke_o           (cke_o),
   .odt_o           (odt_o),
   .freq_change_ok_o(freq_change_ok_o),
   .cmd_o           (cmd_o),
   .busy_o          (busy_o),
   .ready_o         (ready_o),
   .err_o           (err_o)
);

// File: tb/dram_fclk_seq_tb.sv
module dram_fclk_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int PD     = 2;
   localparam int SET    = 1;
   localparam int TXP    = 2;
   localparam int TMRD   = 2;
   localparam int RELOCK = 200;
   localparam int AW     = 14;
   localparam logic [2:0] BL = 3'b010;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0, banks_idle_i = 1'b1, upd_lat_i = 1'b0;
   logic [2:0]    new_cl_i = '0, new_wr_i = '0, new_al_i = '0;
   logic          clk_stable_i = 1'b0, odt_i = 1'b0;
   logic          cke_o, odt_o, freq_change_ok_o, busy_o, ready_o, err_o;
   logic [1:0]    cmd_o, ba_o;
   logic [AW-1:0] addr_o;

   int nchk = 0, nerr = 0, cyc = 0;
   int n_lmr = 0;
   logic [AW-1:0] last_dll = '0;

   // reference state
   bit   m_act = 0, m_upd = 0;
   int   m_rel = 0, m_W = -1;
   logic [2:0] m_cl = 3'd4, m_wr = 3'd2, p_cl = '0, p_wr = '0, p_al = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_fclk_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .banks_idle_i(banks_idle_i),
      .upd_lat_i(upd_lat_i), .new_cl_i(new_cl_i), .new_wr_i(new_wr_i),
      .new_al_i(new_al_i), .clk_stable_i(clk_stable_i), .odt_i(odt_i),
      .cke_o(cke_o), .odt_o(odt_o), .freq_change_ok_o(freq_change_ok_o),
      .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .busy_o(busy_o),
      .ready_o(ready_o), .err_o(err_o)
   );

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         nerr++;
         $display("FAIL watchdog: act=%0d exp=0 (run hung)", cyc);
         summary();
      end
   end

   // timeline model: cycles since acceptance, window-acknowledge cycle
   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_rel = 0; m_W = -1;
      end else if (!m_act) begin
         if (req_i && banks_idle_i) begin
            m_act = 1; m_rel = 1; m_W = -1; m_upd = upd_lat_i;
            p_cl = new_cl_i; p_wr = new_wr_i; p_al = new_al_i;
         end
      end else begin
         if (m_W < 0 && m_rel >= PD + 1 && clk_stable_i) m_W = m_rel;
         if (m_W >= 0 && m_rel == m_W + SET + TXP + 1 + RELOCK) begin
            m_act = 0;
            if (m_upd) begin m_cl = p_cl; m_wr = p_wr; end
         end else
            m_rel++;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s at cycle %0d: act=0x%0h exp=0x%0h", tag, cyc, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] mrw(input logic [2:0] cl, input logic [2:0] wr, input bit dll);
      return AW'((int'(wr) << 9) | (int'(dll) << 8) | (int'(cl) << 4) | int'(BL));
   endfunction

   task automatic compare();
      int D, k;
      bit e_cke, e_fco, e_odt, e_rdy, e_err;
      logic [1:0] e_cmd, e_ba;
      logic [AW-1:0] e_addr;
      string ct;
      D = m_W + SET + TXP + 1;
      k = m_rel - D;
      e_cke = !(m_act && (m_W < 0 || m_rel <= m_W + SET));
      e_fco = m_act && m_W < 0 && m_rel >= PD + 1;
      e_odt = m_act ? 1'b0 : odt_i;
      e_rdy = m_act && m_W >= 0 && m_rel == D + RELOCK;
      e_err = req_i && (m_act || !banks_idle_i);
      e_cmd = 2'b00; e_ba = 2'd0; e_addr = '0;
      ct = m_act ? (m_upd ? "R7" : "R8") : "R10";
      if (m_act && m_W >= 0) begin
         if (k == 0) begin
            e_cmd = 2'b01; e_addr = mrw(m_cl, m_wr, 1'b1); ct = "R6";
         end else if (m_upd && k == TMRD + 1) begin
            e_cmd = 2'b01; e_addr = mrw(p_cl, p_wr, 1'b0); ct = "R7";
         end else if (m_upd && k == 2 * TMRD + 2) begin
            e_cmd = 2'b01; e_ba = 2'd1; e_addr = AW'(int'(p_al) << 3); ct = "R7";
         end
      end
      chk(cke_o == e_cke, (m_W >= 0) ? "R5" : "R2", 32'(cke_o), 32'(e_cke));
      chk(freq_change_ok_o == e_fco, "R3", 32'(freq_change_ok_o), 32'(e_fco));
      chk(odt_o == e_odt, m_act ? "R9" : "R12", 32'(odt_o), 32'(e_odt));
      chk(busy_o == m_act, "R2", 32'(busy_o), 32'(m_act));
      chk(ready_o == e_rdy, "R9", 32'(ready_o), 32'(e_rdy));
      chk(err_o == e_err, "R11", 32'(err_o), 32'(e_err));
      chk(cmd_o == e_cmd, ct, 32'(cmd_o), 32'(e_cmd));
      chk(ba_o == e_ba, ct, 32'(ba_o), 32'(e_ba));
      chk(addr_o == e_addr, ct, 32'(addr_o), 32'(e_addr));
      if (!e_cke) chk(cmd_o == 2'b00, "R10", 32'(cmd_o), 32'd0);
      if (cmd_o == 2'b01) n_lmr++;
      if (e_cmd == 2'b01 && k == 0) last_dll = addr_o;
   endtask

   task automatic step();
      @(negedge clk);
      compare();
   endtask

   // mode 1: early acknowledge pulse then late acknowledge; mode 2: held high from start
   task automatic run_seq(input bit upd, input logic [2:0] cl, input logic [2:0] wr,
                          input logic [2:0] al, input int mode, input int win_wait);
      upd_lat_i = upd; new_cl_i = cl; new_wr_i = wr; new_al_i = al;
      n_lmr = 0;
      req_i = 1'b1;
      step();
      req_i = 1'b0;
      clk_stable_i = 1'b1;
      if (mode == 2) begin
         repeat (PD + 1) step();
         clk_stable_i = 1'b0;
      end else begin
         step();
         clk_stable_i = 1'b0;
         repeat (PD + win_wait) step();
         chk(freq_change_ok_o == 1'b1 && busy_o == 1'b1, "R4", 32'(freq_change_ok_o), 32'd1);
         clk_stable_i = 1'b1;
         step();
         clk_stable_i = 1'b0;
      end
      for (int i = 0; i < 400 && m_act; i++) begin
         req_i = (i == 20);
         step();
      end
      req_i = 1'b0;
      repeat (2) step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      chk(busy_o == 1'b0 && ready_o == 1'b0 && err_o == 1'b0, "R1", 32'(busy_o), 32'd0);
      chk(cke_o == 1'b1 && freq_change_ok_o == 1'b0, "R1", 32'(cke_o), 32'd1);
      chk(cmd_o == 2'b00, "R1", 32'(cmd_o), 32'd0);
      odt_i = 1'b1;
      step();
      chk(odt_o == 1'b1 && cke_o == 1'b1, "R12", 32'(odt_o), 32'd1);

      // request with open banks is refused
      banks_idle_i = 1'b0;
      req_i = 1'b1;
      step();
      req_i = 1'b0;
      step();
      chk(busy_o == 1'b0 && cke_o == 1'b1, "R11", 32'(busy_o), 32'd0);
      banks_idle_i = 1'b1;

      // plain change, early stray acknowledge, request while busy
      run_seq(1'b0, 3'd6, 3'd5, 3'd1, 1, 5);
      chk(n_lmr == 1, "R8", 32'(n_lmr), 32'd1);
      chk(last_dll == mrw(3'd4, 3'd2, 1'b1), "R6", 32'(last_dll), 32'(mrw(3'd4, 3'd2, 1'b1)));

      // change with latency update, acknowledge held from the start
      run_seq(1'b1, 3'd5, 3'd3, 3'd2, 2, 0);
      chk(n_lmr == 3, "R7", 32'(n_lmr), 32'd3);

      // next change reuses the updated values in the DLL-reset load
      run_seq(1'b0, 3'd1, 3'd1, 3'd1, 1, 1);
      chk(n_lmr == 1, "R8", 32'(n_lmr), 32'd1);
      chk(last_dll == mrw(3'd5, 3'd3, 1'b1), "R7", 32'(last_dll), 32'(mrw(3'd5, 3'd3, 1'b1)));

      odt_i = 1'b1;
      step();
      chk(odt_o == 1'b1 && busy_o == 1'b0, "R12", 32'(odt_o), 32'd1);
      summary();
   end

endmodule